// File: doc/BRIEF.md
# UART Register File and Interrupt Controller

This block is the processor-facing side of a classic eight-register byte-wide serial port. Software reaches it through a three-bit offset with separate read and write strobes, one byte per access. Behind it sits a character path: incoming bytes arrive on a valid/ready stream and leave on an outgoing stream that is never stalled. Line timing, baud generation, FIFOs and modem pins belong to other blocks. The block keeps an interrupt-enable byte, a line-control byte (whose top bit redirects offsets 0 and 1 to a divisor latch that is accepted but discarded), a modem-control byte with a single recognised value, and two pending flags, one for receive and one for transmit.

Interrupts are paced. Most events that would raise a pending flag instead start a per-channel timer of `IRQ_DELAY` clock cycles; when the timer runs out the flag is set only if the matching enable bit is still set, and starting a running timer restarts it from zero. The one exception is a new receive byte appearing on an idle stream while receive interrupts are enabled, which sets the receive flag at the next edge. The interrupt output is the OR of both flags, and the identification register only says whether anything is pending.

Receive stream rules: `rx_data` must stay stable while `rx_valid` is high; a byte moves on the edge where `rx_valid` and `rx_ready` are both high, and `rx_ready` rises only during a data read at offset 0 with the divisor-latch bit clear. A rising `rx_valid` after a low cycle counts as a new arrival; `rx_valid` staying high after a pop counts as more data remaining. Transmit stream rules: `tx_valid` pulses for one cycle per data write with the byte on `tx_data`; there is no back-pressure and the sink must take every pulse.

Top module: `uart_regif`

## Requirements
- R1: After reset the enable, line-control and modem-control bytes read 0, both pending flags are clear, `irq` is low and offset 2 reads 1.
- R2: While line-control bit 7 is set, reads of offsets 0 and 1 return 0, writes to them change nothing (no `tx_valid`, enable byte unchanged) and no byte is popped.
- R3: A read of offset 0 with bit 7 clear returns `rx_data` and raises `rx_ready` when `rx_valid` is high, returns 0 with `rx_ready` low otherwise, and always clears the receive pending flag.
- R4: A write to offset 0 with bit 7 clear pulses `tx_valid` with the written byte for that cycle, clears the transmit pending flag, and starts the transmit timer if enable bit 1 is set.
- R5: A write to offset 1 with bit 1 set starts the transmit timer; with bit 1 clear it stops the timer and clears the transmit pending flag.
- R6: A write to offset 1 with bit 0 set while `rx_valid` is high starts the receive timer; any other write to offset 1 stops that timer and clears the receive pending flag.
- R7: A timer started at clock edge E expires at edge E+`IRQ_DELAY` and then sets its pending flag only if its enable bit (bit 0 receive, bit 1 transmit) is set; starting a running timer restarts the count.
- R8: If a data read occurred in the previous cycle, `rx_valid` is high and enable bit 0 is set, the receive timer starts (unless offset 1 is written in that cycle).
- R9: When `rx_valid` rises from low while enable bit 0 is set, the receive pending flag is set at that edge, with no delay.
- R10: Offset 2 reads 0 when either pending flag is set and 1 when neither is; `irq` is high exactly when a pending flag is set.
- R11: Offset 5 reads with bit 0 equal to `rx_valid`, bits 5 and 6 set and all other bits 0; offsets 6 and 7 read 0; writes to offsets 2 and 7 have no effect.
- R12: Writing 0x1A (loopback bit 4 plus 0x0A) to offset 4 makes offset 4 read 0x9A; any other write to offset 4 is ignored.
- R13: Offset 3 stores and reads back the full written byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 3 | Register offset |
| reg_rd | input | 1 | Read strobe, one cycle per access |
| reg_wr | input | 1 | Write strobe, one cycle per access |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid in the cycle of `reg_rd`, 0 otherwise |
| rx_valid | input | 1 | Receive byte available |
| rx_data | input | 8 | Receive byte |
| rx_ready | output | 1 | Receive byte taken this cycle |
| tx_valid | output | 1 | Transmit byte present this cycle |
| tx_data | output | 8 | Transmit byte |
| irq | output | 1 | Interrupt request |

## Verification
The assertions take for granted that software never raises the read and write strobes in the same cycle, and that the receive source keeps its byte steady until it has been popped. The stimulus issues exactly one access or idle per clock and feeds the receive side from a queue that changes `rx_valid` and `rx_data` only between edges and only advances after a sampled handshake. Collisions between a fresh arrival and a same-cycle enable write or data read are kept out of the directed sequence, so pending-flag priorities are checked only where the requirements fix them.

// File: rtl/uart_regif_pkg.sv
package uart_regif_pkg;

  localparam int unsigned ADDR_W = 3;
  localparam int unsigned DATA_W = 8;

  typedef enum logic [ADDR_W-1:0] {
    OFF_DATA    = 3'd0,
    OFF_IEN     = 3'd1,
    OFF_ID      = 3'd2,
    OFF_LINE    = 3'd3,
    OFF_MODEM   = 3'd4,
    OFF_LSTAT   = 3'd5,
    OFF_MSTAT   = 3'd6,
    OFF_SCRATCH = 3'd7
  } reg_off_e;

  // enable bit positions double as timer channel indices
  localparam int unsigned IEN_RX_BIT    = 0;
  localparam int unsigned IEN_TX_BIT    = 1;
  localparam int unsigned NUM_CH        = 2;
  localparam int unsigned LINE_DLAB_BIT = 7;
  localparam int unsigned LS_DR_BIT     = 0;
  localparam int unsigned LS_THRE_BIT   = 5;
  localparam int unsigned LS_TEMT_BIT   = 6;
  localparam int unsigned MC_LOOP_BIT   = 4;

  localparam logic [DATA_W-1:0] MC_MAGIC_WR  = DATA_W'(1 << MC_LOOP_BIT) | 8'h0A;
  localparam logic [DATA_W-1:0] MC_MAGIC_VAL = 8'h9A;

  typedef struct packed {
    logic data_rd;
    logic data_wr;
    logic ien_wr;
    logic line_wr;
    logic modem_wr;
  } strobe_t;

endpackage

// File: rtl/uart_regif_decode.sv
module uart_regif_decode
  import uart_regif_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  input  logic              dlab,
  output strobe_t           stb
);

  always_comb begin
    stb = '0;
    case (reg_off_e'(addr))
      OFF_DATA: begin
        stb.data_rd = rd & ~dlab;
        stb.data_wr = wr & ~dlab;
      end
      OFF_IEN:   stb.ien_wr   = wr & ~dlab;
      OFF_LINE:  stb.line_wr  = wr;
      OFF_MODEM: stb.modem_wr = wr;
      default:   stb = '0;
    endcase
  end

endmodule

// File: rtl/uart_irq_timer.sv
module uart_irq_timer #(
  parameter int unsigned DELAY = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic cancel,
  output logic expire
);

  localparam int unsigned CW = (DELAY < 2) ? 1 : $clog2(DELAY);
  localparam logic [CW-1:0] LAST = CW'(DELAY - 1);

  logic          run_q;
  logic [CW-1:0] cnt_q;
  logic          at_end;

  assign at_end = run_q && (cnt_q == LAST);
  assign expire = at_end && !start && !cancel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (cancel) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (start) begin
      run_q <= 1'b1;
      cnt_q <= '0;
    end else if (at_end) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (run_q) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/uart_regif.sv
module uart_regif
  import uart_regif_pkg::*;
#(
  parameter int unsigned IRQ_DELAY = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  output logic              rx_ready,
  output logic              tx_valid,
  output logic [DATA_W-1:0] tx_data,
  output logic              irq
);

  logic [DATA_W-1:0] ier_q, lcr_q, mcr_q;
  logic              rx_pend_q, tx_pend_q;
  logic              rx_seen_q, pop_q;
  logic              dlab, rx_arrive;
  strobe_t           stb;
  logic [NUM_CH-1:0] t_start, t_cancel, t_expire;
  logic [DATA_W-1:0] rd_mux;

  assign dlab = lcr_q[LINE_DLAB_BIT];

  uart_regif_decode u_dec (
    .addr (reg_addr),
    .rd   (reg_rd),
    .wr   (reg_wr),
    .dlab (dlab),
    .stb  (stb)
  );

  // timer start/cancel per channel
  assign t_start[IEN_TX_BIT]  = (stb.ien_wr & reg_wdata[IEN_TX_BIT])
                              | (stb.data_wr & ier_q[IEN_TX_BIT]);
  assign t_cancel[IEN_TX_BIT] = stb.ien_wr & ~reg_wdata[IEN_TX_BIT];
  assign t_start[IEN_RX_BIT]  = stb.ien_wr ? (reg_wdata[IEN_RX_BIT] & rx_valid)
                                           : (pop_q & rx_valid & ier_q[IEN_RX_BIT]);
  assign t_cancel[IEN_RX_BIT] = stb.ien_wr & ~(reg_wdata[IEN_RX_BIT] & rx_valid);

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_timer
    uart_irq_timer #(.DELAY(IRQ_DELAY)) u_tmr (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (t_start[ch]),
      .cancel (t_cancel[ch]),
      .expire (t_expire[ch])
    );
  end

  assign rx_arrive = rx_valid & ~rx_seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ier_q     <= '0;
      lcr_q     <= '0;
      mcr_q     <= '0;
      rx_seen_q <= 1'b0;
      pop_q     <= 1'b0;
    end else begin
      rx_seen_q <= rx_valid;
      pop_q     <= stb.data_rd;
      if (stb.ien_wr)  ier_q <= reg_wdata;
      if (stb.line_wr) lcr_q <= reg_wdata;
      if (stb.modem_wr && (reg_wdata == MC_MAGIC_WR)) mcr_q <= MC_MAGIC_VAL;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_pend_q <= 1'b0;
    end else if (t_cancel[IEN_TX_BIT] || stb.data_wr) begin
      tx_pend_q <= 1'b0;
    end else if (t_expire[IEN_TX_BIT] && ier_q[IEN_TX_BIT]) begin
      tx_pend_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_pend_q <= 1'b0;
    end else if (t_cancel[IEN_RX_BIT] || stb.data_rd) begin
      rx_pend_q <= 1'b0;
    end else if ((rx_arrive || t_expire[IEN_RX_BIT]) && ier_q[IEN_RX_BIT]) begin
      rx_pend_q <= 1'b1;
    end
  end

  assign irq = rx_pend_q | tx_pend_q;

  always_comb begin
    rd_mux = '0;
    case (reg_off_e'(reg_addr))
      OFF_DATA:  if (!dlab && rx_valid) rd_mux = rx_data;
      OFF_IEN:   if (!dlab) rd_mux = ier_q;
      OFF_ID:    rd_mux[0] = ~irq;
      OFF_LINE:  rd_mux = lcr_q;
      OFF_MODEM: rd_mux = mcr_q;
      OFF_LSTAT: begin
        rd_mux[LS_DR_BIT]   = rx_valid;
        rd_mux[LS_THRE_BIT] = 1'b1;
        rd_mux[LS_TEMT_BIT] = 1'b1;
      end
      default:   rd_mux = '0;
    endcase
  end

  assign reg_rdata = reg_rd ? rd_mux : '0;
  assign rx_ready  = stb.data_rd & rx_valid;
  assign tx_valid  = stb.data_wr;
  assign tx_data   = reg_wdata;

endmodule

// File: rtl/uart_regif_chk.sv
module uart_regif_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] reg_addr,
  input logic       reg_rd,
  input logic       reg_wr,
  input logic [7:0] reg_wdata,
  input logic [7:0] reg_rdata,
  input logic       rx_valid,
  input logic       rx_ready,
  input logic       tx_valid,
  input logic       irq,
  input logic [7:0] ier_q,
  input logic [7:0] lcr_q,
  input logic       rx_pend_q,
  input logic       tx_pend_q
);

  a_r3_one_access_per_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_rd && reg_wr));

  a_r10_id_matches_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == 3'd2) |-> (reg_rdata == {7'd0, !irq}));

  a_r11_line_status: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == 3'd5) |-> (reg_rdata == {1'b0, 2'b11, 4'b0000, rx_valid}));

  a_r3_pop_needs_data_read: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready |-> (rx_valid && reg_rd && reg_addr == 3'd0 && !lcr_q[7]));

  a_r2_latch_mode_blocks_tx: assert property (@(posedge clk) disable iff (!rst_n)
    lcr_q[7] |-> !tx_valid);

  a_r4_send_clears_tx: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |=> !tx_pend_q);

  a_r3_read_clears_rx: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == 3'd0 && !lcr_q[7]) |=> !rx_pend_q);

  a_r5_disable_drops_tx: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 3'd1 && !lcr_q[7] && !reg_wdata[1]) |=> !tx_pend_q);

  a_r6_disable_drops_rx: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 3'd1 && !lcr_q[7] && !reg_wdata[0]) |=> !rx_pend_q);

  a_r7_tx_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_pend_q) |-> $past(ier_q[1]));

  a_r7_rx_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_pend_q) |-> $past(ier_q[0]));

endmodule

bind uart_regif uart_regif_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_addr  (reg_addr),
  .reg_rd    (reg_rd),
  .reg_wr    (reg_wr),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .rx_valid  (rx_valid),
  .rx_ready  (rx_ready),
  .tx_valid  (tx_valid),
  .irq       (irq),
  .ier_q     (ier_q),
  .lcr_q     (lcr_q),
  .rx_pend_q (rx_pend_q),
  .tx_pend_q (tx_pend_q)
);

// File: tb/uart_regif_test.sv
`timescale 1ns/1ps
module uart_regif_test;

  localparam int DLY = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] reg_addr = '0;
  logic       reg_rd = 1'b0, reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_data = '0;
  logic       rx_ready, tx_valid, irq;
  logic [7:0] tx_data;

  always #10 clk = ~clk;

  uart_regif #(.IRQ_DELAY(DLY)) uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_ready(rx_ready), .tx_valid(tx_valid), .tx_data(tx_data), .irq(irq)
  );

  int n_cmp = 0, n_bad = 0;
  logic [7:0] rxq[$];
  bit rx_en = 0;

  // reference model state
  logic [7:0] m_ier = 0, m_lcr = 0, m_mcr = 0;
  bit m_rxp = 0, m_txp = 0, m_prev_v = 0, m_post_pop = 0;
  int m_rx_left = 0, m_tx_left = 0;

  logic [7:0] last_rdata;
  bit last_ready, last_txv;
  logic [7:0] last_txd;

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic string rd_tag(input logic [2:0] a);
    case (a)
      3'd0: return "R3";
      3'd1: return "R5";
      3'd2: return "R10";
      3'd3: return "R13";
      3'd4: return "R12";
      default: return "R11";
    endcase
  endfunction

  task automatic model_compare(input bit rd, input bit wr, input logic [2:0] a, input logic [7:0] d);
    bit dl = m_lcr[7];
    logic [7:0] er = 8'h00;
    if (rd) begin
      case (a)
        3'd0: er = (!dl && rx_valid) ? rx_data : 8'h00;
        3'd1: er = dl ? 8'h00 : m_ier;
        3'd2: er = (m_rxp || m_txp) ? 8'h00 : 8'h01;
        3'd3: er = m_lcr;
        3'd4: er = m_mcr;
        3'd5: er = 8'h60 | {7'd0, rx_valid};
        default: er = 8'h00;
      endcase
    end
    check(rd_tag(a), "rdata", reg_rdata, er);
    check(dl ? "R2" : "R3", "rx_ready", rx_ready, rd && a == 0 && !dl && rx_valid);
    check(dl ? "R2" : "R4", "tx_valid", tx_valid, wr && a == 0 && !dl);
    if (tx_valid) check("R4", "tx_data", tx_data, d);
    check("R10", "irq", irq, m_rxp || m_txp);
  endtask

  task automatic model_step(input bit rd, input bit wr, input logic [2:0] a, input logic [7:0] d, input bit v);
    bit dl = m_lcr[7];
    bit thr = wr && a == 0 && !dl;
    bit ienw = wr && a == 1 && !dl;
    bit drd = rd && a == 0 && !dl;
    bit arrive = v && !m_prev_v;
    bit tx_go = (ienw && d[1]) || (thr && m_ier[1]);
    bit tx_stop = ienw && !d[1];
    bit rx_go = ienw ? (d[0] && v) : (m_post_pop && v && m_ier[0]);
    bit rx_stop = ienw && !(d[0] && v);
    bit tx_fire = !tx_go && !tx_stop && m_tx_left == 1;
    bit rx_fire = !rx_go && !rx_stop && m_rx_left == 1;
    if (tx_stop || thr) m_txp = 0;
    else if (tx_fire && m_ier[1]) m_txp = 1;
    if (rx_stop || drd) m_rxp = 0;
    else if ((arrive || rx_fire) && m_ier[0]) m_rxp = 1;
    m_tx_left = tx_stop ? 0 : tx_go ? DLY : (m_tx_left > 0 ? m_tx_left - 1 : 0);
    m_rx_left = rx_stop ? 0 : rx_go ? DLY : (m_rx_left > 0 ? m_rx_left - 1 : 0);
    if (ienw) m_ier = d;
    if (wr && a == 3) m_lcr = d;
    if (wr && a == 4 && d == 8'h1A) m_mcr = 8'h9A;
    m_post_pop = drd;
    m_prev_v = v;
  endtask

  task automatic cyc(input bit rd, input bit wr, input logic [2:0] a, input logic [7:0] d);
    bit v;
    @(negedge clk);
    reg_rd = rd; reg_wr = wr; reg_addr = a; reg_wdata = d;
    rx_valid = rx_en && rxq.size() != 0;
    rx_data = rx_valid ? rxq[0] : 8'h00;
    v = rx_valid;
    #2;
    model_compare(rd, wr, a, d);
    last_rdata = reg_rdata; last_ready = rx_ready; last_txv = tx_valid; last_txd = tx_data;
    @(posedge clk);
    model_step(rd, wr, a, d, v);
    if (last_ready) void'(rxq.pop_front());
    #1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 3'd0, 8'h00);
  endtask
  task automatic wr(input logic [2:0] a, input logic [7:0] d); cyc(0, 1, a, d); endtask
  task automatic rd_exp(input logic [2:0] a, input logic [7:0] e, input string tag);
    cyc(1, 0, a, 8'h00);
    check(tag, "directed read", last_rdata, e);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check("R1", "irq after reset", irq, 0);
    rd_exp(3'd2, 8'h01, "R1");
    rd_exp(3'd1, 8'h00, "R1");
    rd_exp(3'd3, 8'h00, "R1");
    rd_exp(3'd4, 8'h00, "R1");
    // R13 line control
    wr(3'd3, 8'h03);
    rd_exp(3'd3, 8'h03, "R13");
    // R4 send without enable
    wr(3'd0, 8'h41);
    check("R4", "tx pulse", last_txv, 1);
    check("R4", "tx byte", last_txd, 8'h41);
    idle(8);
    check("R4", "no irq without enable", irq, 0);
    // R5 enable tx, delay
    wr(3'd1, 8'h02);
    idle(DLY - 1);
    check("R7", "tx not yet expired", irq, 0);
    idle(1);
    check("R5", "tx irq after delay", irq, 1);
    rd_exp(3'd2, 8'h00, "R10");
    wr(3'd0, 8'h42);
    check("R4", "send clears tx", irq, 0);
    idle(DLY - 1);
    check("R4", "tx delay running", irq, 0);
    idle(1);
    check("R4", "tx irq after send delay", irq, 1);
    wr(3'd1, 8'h00);
    check("R5", "disable clears tx", irq, 0);
    // R7 restart
    wr(3'd1, 8'h02);
    idle(3);
    wr(3'd1, 8'h02);
    idle(DLY - 1);
    check("R7", "restart postpones", irq, 0);
    idle(1);
    check("R7", "restarted timer fires", irq, 1);
    wr(3'd1, 8'h00);
    // R9 immediate arrival
    wr(3'd1, 8'h01);
    rxq.push_back(8'h55); rxq.push_back(8'h66); rx_en = 1;
    idle(1);
    check("R9", "arrival irq immediate", irq, 1);
    rd_exp(3'd0, 8'h55, "R3");
    check("R3", "pop handshake", last_ready, 1);
    check("R3", "read clears rx", irq, 0);
    idle(DLY);
    check("R8", "remaining data delay running", irq, 0);
    idle(1);
    check("R8", "remaining data irq", irq, 1);
    rd_exp(3'd0, 8'h66, "R3");
    idle(10);
    check("R8", "no restart when empty", irq, 0);
    rd_exp(3'd0, 8'h00, "R3");
    check("R3", "empty read no pop", last_ready, 0);
    // R11 line status
    rd_exp(3'd5, 8'h60, "R11");
    rxq.push_back(8'h77);
    rd_exp(3'd5, 8'h61, "R11");
    rd_exp(3'd0, 8'h77, "R3");
    // R6 receive enable with data present
    wr(3'd1, 8'h00);
    rxq.push_back(8'h12);
    idle(2);
    check("R6", "no irq while disabled", irq, 0);
    wr(3'd1, 8'h01);
    idle(DLY - 1);
    check("R6", "rx delay running", irq, 0);
    idle(1);
    check("R6", "rx irq after enable", irq, 1);
    wr(3'd1, 8'h00);
    check("R6", "disable clears rx", irq, 0);
    rd_exp(3'd0, 8'h12, "R3");
    // R2 divisor latch mode
    wr(3'd3, 8'h83);
    wr(3'd0, 8'h99);
    check("R2", "no tx in latch mode", last_txv, 0);
    wr(3'd1, 8'hFF);
    rd_exp(3'd1, 8'h00, "R2");
    rxq.push_back(8'h21);
    rd_exp(3'd0, 8'h00, "R2");
    check("R2", "no pop in latch mode", last_ready, 0);
    wr(3'd3, 8'h03);
    rd_exp(3'd1, 8'h00, "R2");
    rd_exp(3'd0, 8'h21, "R2");
    // R11 unused registers
    rd_exp(3'd6, 8'h00, "R11");
    wr(3'd7, 8'h5A);
    rd_exp(3'd7, 8'h00, "R11");
    wr(3'd2, 8'hC7);
    rd_exp(3'd2, 8'h01, "R11");
    // R12 modem control
    wr(3'd4, 8'h10);
    rd_exp(3'd4, 8'h00, "R12");
    wr(3'd4, 8'h1A);
    rd_exp(3'd4, 8'h9A, "R12");
    wr(3'd4, 8'h00);
    rd_exp(3'd4, 8'h9A, "R12");
    idle(2);
    summary();
    $finish;
  end

endmodule